// File: doc/BRIEF.md
# Counting Ramp ADC Controller

This block is the digital half of a counting analogue-to-digital converter. It drives an unsigned code to an external DAC and reads back one comparator bit that goes high when the DAC output is above the sampled input. Each conversion starts the code at zero and steps it up by one. After every step it waits a fixed number of clocks for the DAC and comparator to settle, then reads the comparator. The first code that trips the comparator becomes the result, so the result is rounded up to the next code above the input.

Conversions are started by a free-running prescaler that runs on the same clock. Each time the prescaler's top bit rises, the code is forced back to zero and a new conversion begins, even if the previous one has not finished. The comparator bit is asynchronous to the clock and passes through a two-flop synchronizer. When the code reaches all ones and the comparator has still not tripped, the conversion ends with all ones and an overrange flag.

Top module: `ramp_adc`

## Requirements
- R1: While reset is asserted and just after it is released, `dac_code_o`, `result_o`, `done_o` and `over_o` are all zero.
- R2: The prescaler counts clocks from zero after reset. When its bit PRESC_W-1 rises, the code is loaded with zero at the next clock edge. With PRESC_W=7 this load happens at clock edge 65 after reset, and then every 128 clocks.
- R3: During a conversion the code changes only by +1. Each nonzero code stays on `dac_code_o` for exactly SETTLE+1 clocks.
- R4: The comparator reaches the sampling logic through a two-flop synchronizer. The comparator is sampled only after SETTLE clocks of waiting, so with SETTLE of 2 or more the sampled value belongs to the code on the DAC.
- R5: The result is the first code for which the comparator reads high. An input below code 0 gives 0. An input threshold t with 0 <= t <= 14 gives t+1.
- R6: `done_o` is high for exactly one clock. It rises (r+1)*(SETTLE+1) clocks after the zero-load edge, where r is the result.
- R7: `result_o` and `over_o` change only in the cycle in which `done_o` is high. Otherwise they hold.
- R8: If the comparator is still low when the all-ones code is sampled, the result is all ones with `over_o`=1. If it trips at all ones, `over_o`=0.
- R9: A restart during a conversion aborts it. The code returns to zero, and no `done_o` pulse comes from the aborted conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 1 | Comparator bit, high when the DAC output is above the input; asynchronous |
| dac_code_o | output | WIDTH | Code driven to the DAC |
| result_o | output | WIDTH | Last completed conversion result |
| done_o | output | 1 | One-clock pulse when `result_o` updates |
| over_o | output | 1 | Set when the last conversion ended at all ones without a trip |

## Verification
Every result arrives at a fixed clock edge. That edge is the zero-load at prescaler count 2^(PRESC_W-1)+1 after reset, plus (r+1)*(SETTLE+1) clocks. The scoreboard stores this edge number with each expected result and compares it with the bench's own clock count when `done_o` is seen. The bench samples at the falling edge, so the value seen after edge n is compared against n. A second instance with a short prescaler period is used for the abort case. On it the bench checks the code at the exact clocks just before and just after the restart.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } conv_state_t;
endpackage

// File: rtl/ramp_adc_sync.sv
module ramp_adc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] shreg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = shreg[STAGES-1];
endmodule

// File: rtl/ramp_adc_presc.sv
module ramp_adc_presc #(
  parameter int PRESC_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic restart_o
);
  logic [PRESC_W-1:0] cnt;
  logic               top_q;
  logic               top_bit;

  assign top_bit = cnt[PRESC_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      top_q <= 1'b0;
    end else begin
      cnt   <= cnt + PRESC_W'(1);
      top_q <= top_bit;
    end
  end

  // rising edge of the prescaler top bit
  assign restart_o = top_bit & ~top_q;

  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !restart_o); // R2
endmodule

// File: rtl/ramp_adc_seq.sv
module ramp_adc_seq
  import ramp_adc_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter int SETTLE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             cmp_s_i,
  output logic [WIDTH-1:0] code_o,
  output logic [WIDTH-1:0] result_o,
  output logic             over_o,
  output logic             done_o
);
  localparam int WCW = $clog2(SETTLE + 2);

  conv_state_t      st;
  logic [WIDTH-1:0] code_q;
  logic [WIDTH-1:0] res_q;
  logic             over_q;
  logic             done_q;
  logic [WCW-1:0]   wcnt;

  function automatic logic at_top(input logic [WIDTH-1:0] c);
    return &c;
  endfunction

  function automatic logic settled(input logic [WCW-1:0] n);
    return n == WCW'(SETTLE);
  endfunction

  // named internal events
  logic sample_ev, trip_ev, top_ev, step_ev, finish_ev;
  assign sample_ev = (st == ST_CONV) && !restart_i && settled(wcnt);
  assign trip_ev   = sample_ev && cmp_s_i;
  assign top_ev    = sample_ev && !cmp_s_i && at_top(code_q);
  assign step_ev   = sample_ev && !cmp_s_i && !at_top(code_q);
  assign finish_ev = trip_ev || top_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      code_q <= '0;
      res_q  <= '0;
      over_q <= 1'b0;
      done_q <= 1'b0;
      wcnt   <= '0;
    end else begin
      done_q <= 1'b0;
      if (restart_i) begin
        st     <= ST_CONV;
        code_q <= '0;
        wcnt   <= '0;
      end else if (st == ST_CONV) begin
        if (finish_ev) begin
          st     <= ST_IDLE;
          res_q  <= code_q;
          over_q <= top_ev;
          done_q <= 1'b1;
        end else if (step_ev) begin
          code_q <= code_q + WIDTH'(1);
          wcnt   <= '0;
        end else begin
          wcnt   <= wcnt + WCW'(1);
        end
      end
    end
  end

  assign code_o   = code_q;
  assign result_o = res_q;
  assign over_o   = over_q;
  assign done_o   = done_q;

  AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(code_q) |-> ($past(restart_i) || code_q == $past(code_q) + WIDTH'(1))); // R3
  AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> code_q == '0); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> ($stable(res_q) && $stable(over_q))); // R7
  AST_OVER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && over_q) |-> at_top(res_q)); // R8
  AST_TRIP_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !over_q) |-> $past(cmp_s_i)); // R5
endmodule

// File: rtl/ramp_adc.sv
module ramp_adc #(
  parameter int WIDTH   = 4,
  parameter int SETTLE  = 3,
  parameter int PRESC_W = 8,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o,
  output logic             over_o
);
  logic cmp_s;
  logic restart;

  ramp_adc_sync #(.STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  ramp_adc_presc #(.PRESC_W(PRESC_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_o (restart)
  );

  ramp_adc_seq #(.WIDTH(WIDTH), .SETTLE(SETTLE)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .cmp_s_i   (cmp_s),
    .code_o    (dac_code_o),
    .result_o  (result_o),
    .over_o    (over_o),
    .done_o    (done_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!done_o && !over_o)); // R1
endmodule

// File: tb/ramp_adc_tb_top.sv
module ramp_adc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W     = 4;
  localparam int S     = 3;
  localparam int PW    = 7;
  localparam int PW_AB = 5;
  localparam int NCONV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int thr = 100;
  int thr_ab = 100;
  int cyc = 0;
  int nchk = 0;
  int nerr = 0;

  logic         cmp, cmp_ab;
  logic [W-1:0] dac_code, result, dac_ab, result_ab;
  logic         done, over, done_ab, over_ab;

  // ideal comparator: DAC above input threshold
  always_comb cmp    = int'(dac_code) > thr;
  always_comb cmp_ab = int'(dac_ab) > thr_ab;

  ramp_adc #(.WIDTH(W), .SETTLE(S), .PRESC_W(PW), .SYNC_N(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp),
    .dac_code_o(dac_code), .result_o(result), .done_o(done), .over_o(over));

  ramp_adc #(.WIDTH(W), .SETTLE(S), .PRESC_W(PW_AB), .SYNC_N(2)) dut_ab (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp_ab),
    .dac_code_o(dac_ab), .result_o(result_ab), .done_o(done_ab), .over_o(over_ab));

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  typedef struct {
    int res;
    int ovr;
    int at;
  } exp_t;
  exp_t sb[$];

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // driver: sets the input threshold before each conversion and queues the expectation
  task automatic drive_conv(input int k, input int t);
    exp_t e;
    int r;
    while (cyc < 128*k + 10) @(negedge clk);
    thr = t;
    if (t < 0)       r = 0;
    else if (t < 15) r = t + 1;
    else             r = 15;
    e.res = r;
    e.ovr = (t >= 15) ? 1 : 0;
    e.at  = 65 + 128*k + (r + 1)*(S + 1);
    sb.push_back(e);
  endtask

  int tlist [NCONV] = '{-1, 0, 5, 9, 14, 15, 20, 3};

  initial begin
    repeat (3) @(negedge clk);
    check(dac_code == 0, "R1 code in reset", int'(dac_code), 0);
    check(result == 0,   "R1 result in reset", int'(result), 0);
    check(done == 0,     "R1 done in reset", int'(done), 0);
    check(over == 0,     "R1 over in reset", int'(over), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dac_code == 0 && done == 0, "R1 after release", int'(dac_code), 0);
    for (int k = 0; k < NCONV; k++) drive_conv(k, tlist[k]);
    while (cyc < 128*NCONV + 10) @(negedge clk);
    check(sb.size() == 0, "R6 all conversions completed", sb.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  // monitor / scoreboard
  logic [W-1:0] prev_code = '0;
  int           hold = 0;
  logic [W-1:0] last_res = '0;
  logic         last_ovr = 1'b0;
  logic         prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dac_code != prev_code) begin
        check(dac_code == prev_code + W'(1) || dac_code == 0, "R3 step by one",
              int'(dac_code), int'(prev_code) + 1);
        if (prev_code != 0 && dac_code != 0)
          check(hold == S + 1, "R3 dwell per code", hold, S + 1);
        hold = 1;
      end else begin
        hold++;
      end
      prev_code = dac_code;

      check(!(prev_done && done), "R6 done single cycle", int'(done), 0);
      if (done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R6 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(int'(result) == e.res, "R5 R4 result rounded up", int'(result), e.res);
          check(int'(over) == e.ovr, "R8 overrange flag", int'(over), e.ovr);
          check(cyc == e.at, "R2 R6 done timing", cyc, e.at);
        end
        last_res = result;
        last_ovr = over;
      end else begin
        check(result == last_res && over == last_ovr, "R7 result held",
              int'(result), int'(last_res));
      end
      prev_done = done;

      // abort instance: period 32, load at edge 17, restart load at edge 49
      if (cyc == 48) check(dac_ab == 7, "R9 code before abort", int'(dac_ab), 7);
      if (cyc == 49) check(dac_ab == 0, "R9 code after abort", int'(dac_ab), 0);
      if (done_ab) check(1'b0, "R9 aborted conversion raised done", 1, 0);
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    nerr++;
    nchk++;
    $display("FAIL watchdog R6 actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule